// File: doc/BRIEF.md
# JTAG Configuration Status Readback Sequencer

This block is a small JTAG master. After a programmable device has been configured, it reads back the device's 32-bit configuration status word through the test access port. It drives TCK, TMS and TDI itself and samples TDO. TCK runs at half the system clock.

A pulse on the start input runs one fixed sequence. The sequence forces the TAP into Test-Logic-Reset and moves it to Run-Test/Idle. It loads the write-configuration instruction and shifts a 64-bit command pattern, which is a parameter, into the target. It then loads the read-configuration instruction and clocks the status word out of TDO. At the end the block reports three results: the captured word, a CRC-error flag taken from the last bit to arrive, and a flag that is set when the word differs from the expected post-configuration value, which is also a parameter.

The target may sit alone on the chain or among other devices held in BYPASS. Two parameters give the number of devices between TDI and the target and the number between the target and TDO. The block adds the padding bits and the all-ones instruction fields those devices need.

Top module: `jtag_stat_rdbk`

## Requirements
- R1: While reset is held and afterwards until the first start, tck_o, busy_o and done_o are low, and status_o, crc_err_o and mismatch_o are zero.
- R2: Each run first applies at least five TCK cycles with TMS high. This brings the TAP to Test-Logic-Reset from any state. The run then moves the TAP to Run-Test/Idle before the first instruction scan.
- R3: One TCK period is exactly two system clocks, with TCK low in the first clock and high in the second. TMS and TDI change only while TCK is low, and TDO is sampled at the rising TCK edge.
- R4: Instruction scans shift LSB first, and the fields for the devices nearest TDO go first. The target's instruction register gets IR_WR_CODE in the first scan and IR_RD_CODE in the second. Every other device gets all ones (BYPASS).
- R5: The command pattern is shifted bit 63 first. It is followed by UP_DEVS zero bits, so that the whole pattern ends up in the target.
- R6: The readback scan is 32+DOWN_DEVS bits long. The first DOWN_DEVS bits are dropped. The first bit kept becomes status_o[31] and the last becomes status_o[0].
- R7: crc_err_o equals the last status bit received (status_o[0]).
- R8: mismatch_o is high exactly when status_o differs from EXP_STATUS.
- R9: done_o is a one-cycle pulse in the same cycle that busy_o falls. The results are updated only in that cycle and hold until the next run completes. busy_o rises the cycle after an accepted start.
- R10: A start pulse while busy_o is high has no effect on the running sequence and does not queue a second run.
- R11: One run is 2*IR_LEN*(UP_DEVS+DOWN_DEVS+1) + UP_DEVS + DOWN_DEVS + 121 TCK cycles, and it leaves the TAP in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one readback run (ignored while busy) |
| tdo_i | input | 1 | Test data from the last device of the chain |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to the first device of the chain |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| status_o | output | 32 | Captured status word |
| crc_err_o | output | 1 | Last received status bit |
| mismatch_o | output | 1 | Status differs from EXP_STATUS |

## Verification
A behavioural TAP chain model supplies each status word. The words are all zeros, all ones, the expected good value, the good value with only the last bit inverted, and a single walking one at each of the 32 positions. The all-zero and all-one words separate the two result flags. The one-bit variant of the good value has to raise both the CRC flag and the mismatch flag, while the good value raises neither. The walking ones expose any reversal or offset in the bit order. The same sweep runs on a lone target and on a target between one upstream and two downstream bypassed devices, so that missing or misplaced padding bits and bypass fields change the captured word or the command pattern the model receives.

// File: rtl/jsr_pkg.sv
package jsr_pkg;
  localparam int unsigned CMD_W  = 64;
  localparam int unsigned STAT_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_IR_WR,
    ST_GO_DR_WR,
    ST_DR_WR,
    ST_GO_IR_RD,
    ST_IR_RD,
    ST_GO_DR_RD,
    ST_DR_RD,
    ST_TAIL
  } seq_st_e;

  // TMS walks, bit i is the value on the i-th TCK of the segment
  localparam logic [15:0] NAV_RST   = 16'h00DF; // 1,1,1,1,1,0,1,1,0,0 -> Shift-IR
  localparam logic [15:0] NAV_TO_DR = 16'h0003; // Exit1-IR: 1,1,0,0 -> Shift-DR
  localparam logic [15:0] NAV_TO_IR = 16'h0007; // Exit1-DR: 1,1,1,0,0 -> Shift-IR
  localparam logic [15:0] NAV_TAIL  = 16'h0001; // Exit1-DR: 1,0 -> Run-Test/Idle

  localparam int unsigned LEN_RST   = 10;
  localparam int unsigned LEN_TO_DR = 4;
  localparam int unsigned LEN_TO_IR = 5;
  localparam int unsigned LEN_TAIL  = 2;
endpackage

// File: rtl/jsr_tck_gen.sv
module jsr_tck_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tck_o,
  output logic rise_o,
  output logic adv_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ph_q <= 1'b0;
    else if (en_i) ph_q <= ~ph_q;
    else           ph_q <= 1'b0;
  end

  assign tck_o  = ph_q;
  assign rise_o = en_i & ~ph_q;  // TCK goes high at this edge
  assign adv_o  = en_i & ph_q;   // TCK goes low, next bit
endmodule

// File: rtl/jsr_seq.sv
module jsr_seq
  import jsr_pkg::*;
#(
  parameter int unsigned        IR_LEN      = 5,
  parameter logic [IR_LEN-1:0]  IR_WR_CODE  = '0,
  parameter logic [IR_LEN-1:0]  IR_RD_CODE  = '0,
  parameter logic [CMD_W-1:0]   CMD_PATTERN = '0,
  parameter int unsigned        UP_DEVS     = 0,
  parameter int unsigned        DOWN_DEVS   = 0,
  parameter int unsigned        CW          = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic adv_i,
  output logic tms_o,
  output logic tdi_o,
  output logic busy_o,
  output logic cap_o,
  output logic fin_o
);
  localparam int unsigned IR_TOT = IR_LEN * (UP_DEVS + DOWN_DEVS + 1);
  localparam logic [CW-1:0] L_IR    = CW'(IR_TOT);
  localparam logic [CW-1:0] L_DRW   = CW'(CMD_W + UP_DEVS);
  localparam logic [CW-1:0] L_DRR   = CW'(STAT_W + DOWN_DEVS);
  localparam logic [CW-1:0] L_RST   = CW'(LEN_RST);
  localparam logic [CW-1:0] L_TODR  = CW'(LEN_TO_DR);
  localparam logic [CW-1:0] L_TOIR  = CW'(LEN_TO_IR);
  localparam logic [CW-1:0] L_TAIL  = CW'(LEN_TAIL);
  localparam logic [CW-1:0] DN_IR_C = CW'(IR_LEN * DOWN_DEVS);
  localparam logic [CW-1:0] IRL_C   = CW'(IR_LEN);
  localparam logic [CW-1:0] CMDL_C  = CW'(CMD_W);
  localparam logic [IR_LEN-1:0] IR_ONE = IR_LEN'(1);

  seq_st_e st_q, st_nxt;
  logic [CW-1:0] cnt_q, seg_len, rel_ir;
  logic last, in_tgt, skip;

  always_comb begin
    case (st_q)
      ST_RST:                   seg_len = L_RST;
      ST_IR_WR, ST_IR_RD:       seg_len = L_IR;
      ST_GO_DR_WR, ST_GO_DR_RD: seg_len = L_TODR;
      ST_DR_WR:                 seg_len = L_DRW;
      ST_GO_IR_RD:              seg_len = L_TOIR;
      ST_DR_RD:                 seg_len = L_DRR;
      ST_TAIL:                  seg_len = L_TAIL;
      default:                  seg_len = CW'(1);
    endcase
  end

  always_comb begin
    case (st_q)
      ST_RST:      st_nxt = ST_IR_WR;
      ST_IR_WR:    st_nxt = ST_GO_DR_WR;
      ST_GO_DR_WR: st_nxt = ST_DR_WR;
      ST_DR_WR:    st_nxt = ST_GO_IR_RD;
      ST_GO_IR_RD: st_nxt = ST_IR_RD;
      ST_IR_RD:    st_nxt = ST_GO_DR_RD;
      ST_GO_DR_RD: st_nxt = ST_DR_RD;
      ST_DR_RD:    st_nxt = ST_TAIL;
      default:     st_nxt = ST_IDLE;
    endcase
  end

  assign last = (cnt_q == seg_len - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (st_q == ST_IDLE) begin
      cnt_q <= '0;
      if (start_i) st_q <= ST_RST;
    end else if (adv_i) begin
      if (last) begin
        st_q  <= st_nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // wraps above range when cnt is still inside the downstream fields
  assign rel_ir = cnt_q - DN_IR_C;
  assign in_tgt = rel_ir < IRL_C;

  always_comb begin
    tms_o = 1'b0;
    tdi_o = 1'b0;
    case (st_q)
      ST_RST:                   tms_o = |((NAV_RST   >> cnt_q) & 16'd1);
      ST_GO_DR_WR, ST_GO_DR_RD: tms_o = |((NAV_TO_DR >> cnt_q) & 16'd1);
      ST_GO_IR_RD:              tms_o = |((NAV_TO_IR >> cnt_q) & 16'd1);
      ST_TAIL:                  tms_o = |((NAV_TAIL  >> cnt_q) & 16'd1);
      ST_IR_WR: begin
        tms_o = last;
        tdi_o = in_tgt ? |((IR_WR_CODE >> rel_ir) & IR_ONE) : 1'b1;
      end
      ST_IR_RD: begin
        tms_o = last;
        tdi_o = in_tgt ? |((IR_RD_CODE >> rel_ir) & IR_ONE) : 1'b1;
      end
      ST_DR_WR: begin
        tms_o = last;
        tdi_o = (cnt_q < CMDL_C) ?
                |((CMD_PATTERN >> (CMDL_C - CW'(1) - cnt_q)) & 64'd1) : 1'b0;
      end
      ST_DR_RD: tms_o = last;
      default: ;
    endcase
  end

  generate
    if (DOWN_DEVS == 0) begin : g_no_skip
      assign skip = 1'b0;
    end else begin : g_skip
      localparam logic [CW-1:0] DN_C = CW'(DOWN_DEVS);
      assign skip = cnt_q < DN_C;
    end
  endgenerate

  assign busy_o = (st_q != ST_IDLE);
  assign cap_o  = (st_q == ST_DR_RD) && !skip;
  assign fin_o  = adv_i && last && (st_q == ST_TAIL);
endmodule

// File: rtl/jsr_capture.sv
module jsr_capture
  import jsr_pkg::*;
#(
  parameter logic [STAT_W-1:0] EXP_STATUS = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic              tdo_i,
  input  logic              fin_i,
  output logic [STAT_W-1:0] status_o,
  output logic              crc_o,
  output logic              mis_o,
  output logic              done_o
);
  logic [STAT_W-1:0] sr_q, stat_q;
  logic crc_q, mis_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (smp_i) sr_q <= {sr_q[STAT_W-2:0], tdo_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      crc_q  <= 1'b0;
      mis_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_i;
      if (fin_i) begin
        stat_q <= sr_q;
        crc_q  <= sr_q[0];
        mis_q  <= (sr_q != EXP_STATUS);
      end
    end
  end

  assign status_o = stat_q;
  assign crc_o    = crc_q;
  assign mis_o    = mis_q;
  assign done_o   = done_q;
endmodule

// File: rtl/jtag_stat_rdbk.sv
module jtag_stat_rdbk
  import jsr_pkg::*;
#(
  parameter int unsigned        IR_LEN      = 5,
  parameter logic [IR_LEN-1:0]  IR_WR_CODE  = 5'b00101,
  parameter logic [IR_LEN-1:0]  IR_RD_CODE  = 5'b00100,
  parameter logic [63:0]        CMD_PATTERN = 64'hC3A5_0F1E_7B2D_9846,
  parameter logic [31:0]        EXP_STATUS  = 32'h0000_3E5C,
  parameter int unsigned        UP_DEVS     = 0,
  parameter int unsigned        DOWN_DEVS   = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        tdo_i,
  output logic        tck_o,
  output logic        tms_o,
  output logic        tdi_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] status_o,
  output logic        crc_err_o,
  output logic        mismatch_o
);
  localparam int unsigned IR_TOT  = IR_LEN * (UP_DEVS + DOWN_DEVS + 1);
  localparam int unsigned SEG_A   = (IR_TOT > LEN_RST) ? IR_TOT : LEN_RST;
  localparam int unsigned SEG_B   = (CMD_W + UP_DEVS > STAT_W + DOWN_DEVS) ?
                                    CMD_W + UP_DEVS : STAT_W + DOWN_DEVS;
  localparam int unsigned MAX_SEG = (SEG_A > SEG_B) ? SEG_A : SEG_B;
  localparam int unsigned CW      = $clog2(MAX_SEG + 1);

  logic rise, adv, cap, fin, busy;

  jsr_tck_gen u_tck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .tck_o  (tck_o),
    .rise_o (rise),
    .adv_o  (adv)
  );

  jsr_seq #(
    .IR_LEN      (IR_LEN),
    .IR_WR_CODE  (IR_WR_CODE),
    .IR_RD_CODE  (IR_RD_CODE),
    .CMD_PATTERN (CMD_PATTERN),
    .UP_DEVS     (UP_DEVS),
    .DOWN_DEVS   (DOWN_DEVS),
    .CW          (CW)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .adv_i   (adv),
    .tms_o   (tms_o),
    .tdi_o   (tdi_o),
    .busy_o  (busy),
    .cap_o   (cap),
    .fin_o   (fin)
  );

  jsr_capture #(
    .EXP_STATUS (EXP_STATUS)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_i    (rise & cap),
    .tdo_i    (tdo_i),
    .fin_i    (fin),
    .status_o (status_o),
    .crc_o    (crc_err_o),
    .mis_o    (mismatch_o),
    .done_o   (done_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/jtag_stat_rdbk_chk.sv
module jtag_stat_rdbk_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        tck_o,
  input logic        tms_o,
  input logic        tdi_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] status_o
);
  AST_TCK_HIGH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |=> !tck_o); // R3
  AST_PINS_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |-> ($stable(tms_o) && $stable(tdi_o))); // R3
  AST_TCK_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |-> busy_o); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R9
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(status_o)); // R9
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R9
  AST_BUSY_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o)); // R10
endmodule

bind jtag_stat_rdbk jtag_stat_rdbk_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .tck_o    (tck_o),
  .tms_o    (tms_o),
  .tdi_o    (tdi_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .status_o (status_o)
);

// File: tb/tb_jtag_stat_rdbk.sv
`timescale 1ns/1ps

module tb_tap_chain #(
  parameter int          IRL    = 5,
  parameter logic [4:0]  IR_IN  = 5'b00101,
  parameter logic [4:0]  IR_OUT = 5'b00100,
  parameter int          UP     = 0,
  parameter int          DN     = 0
) (
  input  logic        tck,
  input  logic        tms,
  input  logic        tdi,
  input  logic        clr,
  input  logic [31:0] st,
  output logic        tdo,
  output logic [63:0] cmd_seen,
  output logic [4:0]  ir_log0,
  output logic [4:0]  ir_log1,
  output int          ir_n,
  output int          tcks,
  output bit          byp_bad,
  output bit          tlr_seen,
  output logic [3:0]  tap
);
  localparam logic [3:0] TLR=0, RTI=1, SDS=2, CDR=3, SHDR=4, E1DR=5, PDR=6, E2DR=7,
                         UDR=8, SIS=9, CIR=10, SHIR=11, E1IR=12, PIR=13, E2IR=14, UIR=15;
  logic [127:0] ch;
  int L;
  logic [4:0] tir;

  function automatic logic [3:0] nxt(input logic [3:0] s, input logic m);
    case (s)
      TLR:  nxt = m ? TLR  : RTI;
      RTI:  nxt = m ? SDS  : RTI;
      SDS:  nxt = m ? SIS  : CDR;
      CDR:  nxt = m ? E1DR : SHDR;
      SHDR: nxt = m ? E1DR : SHDR;
      E1DR: nxt = m ? UDR  : PDR;
      PDR:  nxt = m ? E2DR : PDR;
      E2DR: nxt = m ? UDR  : SHDR;
      UDR:  nxt = m ? SDS  : RTI;
      SIS:  nxt = m ? TLR  : CIR;
      CIR:  nxt = m ? E1IR : SHIR;
      SHIR: nxt = m ? E1IR : SHIR;
      E1IR: nxt = m ? UIR  : PIR;
      PIR:  nxt = m ? E2IR : PIR;
      E2IR: nxt = m ? UIR  : SHIR;
      default: nxt = m ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck or posedge clr) begin
    if (clr) begin
      tap = SHDR; tir = '0; ch = '0; L = 1;
      cmd_seen = '0; ir_log0 = '0; ir_log1 = '0; ir_n = 0; tcks = 0;
      byp_bad = 0; tlr_seen = 0;
    end else begin
      tcks++;
      case (tap)
        TLR: begin tlr_seen = 1; tir = '1; end
        CDR: begin
          ch = '0;
          if (tir == IR_OUT) begin
            for (int k = 0; k < 32; k++) ch[DN+k] = st[31-k];
            L = DN + 32 + UP;
          end else if (tir == IR_IN) L = DN + 64 + UP;
          else L = DN + 1 + UP;
        end
        CIR: begin ch = '0; L = IRL * (UP + DN + 1); end
        SHDR, SHIR: begin ch = ch >> 1; ch[L-1] = tdi; end
        UDR: if (tir == IR_IN) for (int j = 0; j < 64; j++) cmd_seen[j] = ch[DN+63-j];
        UIR: begin
          tir = ch[DN*IRL +: 5];
          for (int d = 0; d < UP + DN + 1; d++)
            if (d != DN && ch[d*IRL +: 5] != 5'b11111) byp_bad = 1;
          if (ir_n == 0) ir_log0 = tir;
          else if (ir_n == 1) ir_log1 = tir;
          ir_n++;
        end
        default: ;
      endcase
      tap = nxt(tap, tms);
    end
  end

  always @(negedge tck or posedge clr) begin
    if (clr) tdo = 1'b0;
    else if (tap == SHDR || tap == SHIR) tdo = ch[0];
  end
endmodule

module tb_jtag_stat_rdbk;
  localparam logic [4:0]  IR_W  = 5'b00101;
  localparam logic [4:0]  IR_R  = 5'b00100;
  localparam logic [63:0] CMD_A = 64'hC3A5_0F1E_7B2D_9846;
  localparam logic [63:0] CMD_B = 64'h0123_89AB_FEDC_7654;
  localparam logic [31:0] EXP_A = 32'h0000_3E5C;
  localparam logic [31:0] EXP_B = 32'h1234_0F00;
  localparam int UP_A = 1, DN_A = 2;
  localparam int IRT_A = 5 * (UP_A + DN_A + 1);
  localparam int IRT_B = 5;
  localparam int T_A = 2 * IRT_A + UP_A + DN_A + 121; // R11
  localparam int T_B = 2 * IRT_B + 121;

  logic clk = 0, rst_n = 0, clr = 0;
  logic start_a = 0, start_b = 0;
  logic [31:0] st_a = '0, st_b = '0;
  int total = 0, bad = 0;

  logic tck_a, tms_a, tdi_a, tdo_a, busy_a, done_a, crc_a, mis_a;
  logic tck_b, tms_b, tdi_b, tdo_b, busy_b, done_b, crc_b, mis_b;
  logic [31:0] stat_a, stat_b;
  logic [63:0] cmd_a, cmd_b;
  logic [4:0] l0_a, l1_a, l0_b, l1_b;
  int irn_a, irn_b, tk_a, tk_b;
  bit bb_a, bb_b, tlr_a, tlr_b;
  logic [3:0] tap_a, tap_b;
  int dcnt_a = 0, dcnt_b = 0, bcyc_a = 0, bcyc_b = 0;

  always #4 clk = ~clk;

  jtag_stat_rdbk #(.IR_LEN(5), .IR_WR_CODE(IR_W), .IR_RD_CODE(IR_R), .CMD_PATTERN(CMD_A),
    .EXP_STATUS(EXP_A), .UP_DEVS(UP_A), .DOWN_DEVS(DN_A)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .tdo_i(tdo_a), .tck_o(tck_a),
    .tms_o(tms_a), .tdi_o(tdi_a), .busy_o(busy_a), .done_o(done_a), .status_o(stat_a),
    .crc_err_o(crc_a), .mismatch_o(mis_a));

  jtag_stat_rdbk #(.IR_LEN(5), .IR_WR_CODE(IR_W), .IR_RD_CODE(IR_R), .CMD_PATTERN(CMD_B),
    .EXP_STATUS(EXP_B), .UP_DEVS(0), .DOWN_DEVS(0)) dut_one (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .tdo_i(tdo_b), .tck_o(tck_b),
    .tms_o(tms_b), .tdi_o(tdi_b), .busy_o(busy_b), .done_o(done_b), .status_o(stat_b),
    .crc_err_o(crc_b), .mismatch_o(mis_b));

  tb_tap_chain #(.IRL(5), .IR_IN(IR_W), .IR_OUT(IR_R), .UP(UP_A), .DN(DN_A)) m_a (
    .tck(tck_a), .tms(tms_a), .tdi(tdi_a), .clr(clr), .st(st_a), .tdo(tdo_a),
    .cmd_seen(cmd_a), .ir_log0(l0_a), .ir_log1(l1_a), .ir_n(irn_a), .tcks(tk_a),
    .byp_bad(bb_a), .tlr_seen(tlr_a), .tap(tap_a));

  tb_tap_chain #(.IRL(5), .IR_IN(IR_W), .IR_OUT(IR_R), .UP(0), .DN(0)) m_b (
    .tck(tck_b), .tms(tms_b), .tdi(tdi_b), .clr(clr), .st(st_b), .tdo(tdo_b),
    .cmd_seen(cmd_b), .ir_log0(l0_b), .ir_log1(l1_b), .ir_n(irn_b), .tcks(tk_b),
    .byp_bad(bb_b), .tlr_seen(tlr_b), .tap(tap_b));

  always @(negedge clk) begin
    if (done_a) dcnt_a++;
    if (done_b) dcnt_b++;
    if (busy_a) bcyc_a++;
    if (busy_b) bcyc_b++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_side(input string tag, input logic [31:0] st, input logic [31:0] exp,
      input logic [31:0] stat, input logic crc, input logic mis, input logic [63:0] cmd,
      input logic [63:0] cmd_exp, input logic [4:0] l0, input logic [4:0] l1, input int irn,
      input bit bb, input bit tlr, input logic [3:0] tap, input int tk, input int texp,
      input int bcyc, input int dd);
    chk(stat == st, {"R6 status word ", tag}, 64'(stat), 64'(st));
    chk(crc == st[0], {"R7 crc flag ", tag}, 64'(crc), 64'(st[0]));
    chk(mis == (st != exp), {"R8 mismatch ", tag}, 64'(mis), 64'(st != exp));
    chk(cmd == cmd_exp, {"R5 command in target ", tag}, cmd, cmd_exp);
    chk(l0 == IR_W && l1 == IR_R && irn == 2, {"R4 target instructions ", tag},
        64'({l0, l1}), 64'({IR_W, IR_R}));
    chk(!bb, {"R4 bypass fields all ones ", tag}, 64'(bb), 64'd0);
    chk(tlr, {"R2 Test-Logic-Reset reached ", tag}, 64'(tlr), 64'd1);
    chk(tap == 4'd1, {"R11 ends in Run-Test/Idle ", tag}, 64'(tap), 64'd1);
    chk(tk == texp, {"R11 TCK count ", tag}, 64'(tk), 64'(texp));
    chk(bcyc == 2 * texp, {"R3 two clocks per TCK ", tag}, 64'(bcyc), 64'(2 * texp));
    chk(dd == 1, {"R9 one done pulse ", tag}, 64'(dd), 64'd1);
  endtask

  task automatic run_both(input logic [31:0] st, input bit extra);
    int da0, db0, ba0, bb0, n;
    st_a = st; st_b = st;
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    da0 = dcnt_a; db0 = dcnt_b; ba0 = bcyc_a; bb0 = bcyc_b;
    @(negedge clk) begin start_a = 1; start_b = 1; end
    @(negedge clk) begin start_a = 0; start_b = 0; end
    if (extra) begin
      repeat (100) @(negedge clk);
      start_a = 1; start_b = 1;
      @(negedge clk) begin start_a = 0; start_b = 0; end
    end
    n = 0;
    while ((dcnt_a == da0 || dcnt_b == db0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (extra) begin
      repeat (300) @(negedge clk);
      chk(!busy_a && !busy_b, "R10 no queued run", 64'({busy_a, busy_b}), 64'd0);
    end
    @(negedge clk);
    check_side("chain", st, EXP_A, stat_a, crc_a, mis_a, cmd_a, CMD_A, l0_a, l1_a, irn_a,
               bb_a, tlr_a, tap_a, tk_a, T_A, bcyc_a - ba0, dcnt_a - da0);
    check_side("single", st, EXP_B, stat_b, crc_b, mis_b, cmd_b, CMD_B, l0_b, l1_b, irn_b,
               bb_b, tlr_b, tap_b, tk_b, T_B, bcyc_b - bb0, dcnt_b - db0);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!tck_a && !busy_a && !done_a && stat_a == 0 && !crc_a && !mis_a,
        "R1 reset outputs", 64'({tck_a, busy_a, done_a, crc_a, mis_a}), 64'd0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!tck_b && !busy_b && !done_b && stat_b == 0 && !crc_b && !mis_b,
        "R1 idle after reset", 64'({tck_b, busy_b, done_b, crc_b, mis_b}), 64'd0);

    run_both(32'h0000_0000, 1'b0);
    run_both(32'hFFFF_FFFF, 1'b0);
    run_both(EXP_A, 1'b0);
    run_both(EXP_A ^ 32'h1, 1'b0);
    run_both(EXP_B, 1'b0);
    for (int i = 0; i < 32; i++) run_both(32'h1 << i, 1'b0);
    run_both(32'hA5C3_1E0F, 1'b1); // R10

    repeat (10) @(negedge clk);
    chk(stat_a == 32'hA5C3_1E0F, "R9 result held", 64'(stat_a), 64'hA5C3_1E0F);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule